// File: doc/BRIEF.md
# Modulo-5 Up/Down Counter State Machine

This block is a synchronous state machine that walks through five count values, 0 to 4, one step per clock while its enable is high. A direction input picks whether the count rises or falls. A single Mealy output, `wrap`, marks the step that crosses from one end of the range to the other in either direction. The three state bits are driven straight out as the count value, so the block serves as both a small sequencer and a counter.

The way the state flip-flops are excited is chosen at build time. The choices are plain data flip-flops, toggle flip-flops, or J-K flip-flops with J and K tied together. All three follow the same sequence. The three binary codes above 4 are never reached in normal use. If one is ever present, the machine leaves it on the next active edge and goes to zero. The reset input is active-low and asserts asynchronously. Its release passes through a two-stage synchroniser inside the block.

Top module: `mod5_updown_counter`

## Requirements
- R1: While `rst_n` is 0, `count` is 000 at once. After `rst_n` rises, the state stays at its reset value for two further rising edges and may change from the third edge on.
- R2: With `en` = 0, `count` keeps its value across every edge and `wrap` is 0, whatever `up` is.
- R3: With `en` = 1 and `up` = 1, `count` steps 000, 001, 010, 011, 100, 000 (most significant bit first) on successive edges.
- R4: With `en` = 1 and `up` = 0, `count` steps 000, 100, 011, 010, 001, 000.
- R5: `wrap` is 1 when `en` = 1, `up` = 1 and `count` = 100, and that edge takes `count` to 000.
- R6: `wrap` is 1 when `en` = 1, `up` = 0 and `count` = 000, and that edge takes `count` to 100.
- R7: `wrap` is 0 in every other combination of state and inputs. It follows a change of `en` or `up` in the same cycle, without waiting for a clock edge.
- R8: From any of the codes 101, 110 or 111, the next active edge loads 000 whatever `en` and `up` are, and `wrap` stays 0 while such a code is present.
- R9: The data, toggle and J-K excitation variants (parameter `EXCITE`) produce identical `count` and `wrap` sequences for identical inputs.
- R10: `count` is the state register itself. It changes only on a rising clock edge or on reset assertion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low, release synchronised inside |
| en | input | 1 | Count enable |
| up | input | 1 | Direction: 1 counts up, 0 counts down |
| wrap | output | 1 | Combinational wrap flag for the current step |
| count | output | 3 | Present state, most significant bit first |

## Verification
Two events can fall in the same cycle: the end-of-range wrap and a change of direction. When the state sits at 000 or 100 and `up` flips between edges, `wrap` has to move at once to the value for the new direction. The next edge has to take the matching branch, which may be a wrap or an ordinary step. Long random runs of `en` and `up` create many such cycles in all three excitation variants. A behavioural model judges them: `wrap` is checked after each input change and before the edge, and `count` is checked after the edge. Recovery is checked on instances whose reset value is an unused code. Those instances keep their enable high throughout, so the jump back to 000 overlaps the first cycles after the reset release.

// File: rtl/mod5_pkg.sv
package mod5_pkg;
  // Flip-flop excitation style for the state register
  typedef enum logic [1:0] {
    EXC_D  = 2'd0,
    EXC_T  = 2'd1,
    EXC_JK = 2'd2
  } excite_e;
endpackage

// File: rtl/mod5_rst_sync.sv
module mod5_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/mod5_next_state.sv
module mod5_next_state #(
  parameter int MODULUS = 5,
  parameter int W       = 3
) (
  input  logic [W-1:0] cur,
  input  logic         en,
  input  logic         up,
  output logic [W-1:0] nxt,
  output logic         wrap
);
  localparam logic [W-1:0] TOP  = W'(MODULUS - 1);
  localparam logic [W-1:0] ZERO = '0;

  logic legal;
  logic at_top;
  logic at_zero;

  assign legal   = (cur <= TOP);
  assign at_top  = (cur == TOP);
  assign at_zero = (cur == ZERO);

  always_comb begin
    nxt  = cur;
    wrap = 1'b0;
    if (!legal) begin
      nxt = ZERO;
    end else if (en) begin
      if (up) begin
        nxt  = at_top ? ZERO : cur + W'(1);
        wrap = at_top;
      end else begin
        nxt  = at_zero ? TOP : cur - W'(1);
        wrap = at_zero;
      end
    end
  end
endmodule

// File: rtl/mod5_state_reg.sv
module mod5_state_reg
  import mod5_pkg::*;
#(
  parameter int      W      = 3,
  parameter excite_e EXCITE = EXC_D,
  parameter int      SEED   = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] nxt,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] SEED_V = W'(SEED);

  logic [W-1:0] flip;
  assign flip = q ^ nxt;

  generate
    if (EXCITE == EXC_D) begin : g_d
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= SEED_V;
        else        q <= nxt;
      end
    end else if (EXCITE == EXC_T) begin : g_t
      for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)       q[i] <= SEED_V[i];
          else if (flip[i]) q[i] <= ~q[i];
        end
      end
    end else begin : g_jk
      for (genvar i = 0; i < W; i++) begin : g_bit
        logic j_in;
        logic k_in;
        logic d_jk;
        assign j_in = flip[i];
        assign k_in = flip[i];
        always_comb begin
          d_jk = (j_in & ~q[i]) | (~k_in & q[i]);
        end
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) q[i] <= SEED_V[i];
          else        q[i] <= d_jk;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/mod5_updown_counter.sv
module mod5_updown_counter
  import mod5_pkg::*;
#(
  parameter int      MODULUS = 5,
  parameter excite_e EXCITE  = EXC_D,
  parameter int      SEED    = 0,
  parameter int      W       = $clog2(MODULUS)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         up,
  output logic         wrap,
  output logic [W-1:0] count
);
  logic         rst_q_n;
  logic [W-1:0] state;
  logic [W-1:0] state_nxt;

  mod5_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_q_n)
  );

  mod5_next_state #(.MODULUS(MODULUS), .W(W)) u_next (
    .cur  (state),
    .en   (en),
    .up   (up),
    .nxt  (state_nxt),
    .wrap (wrap)
  );

  mod5_state_reg #(.W(W), .EXCITE(EXCITE), .SEED(SEED)) u_reg (
    .clk   (clk),
    .rst_n (rst_q_n),
    .nxt   (state_nxt),
    .q     (state)
  );

  assign count = state;
endmodule

// File: rtl/mod5_chk.sv
module mod5_chk #(
  parameter int MODULUS = 5,
  parameter int W       = 3
) (
  input logic         clk,
  input logic         rst_n,
  input logic         en,
  input logic         up,
  input logic         wrap,
  input logic [W-1:0] count
);
  localparam logic [W-1:0] TOP = W'(MODULUS - 1);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && count <= TOP) |=> $stable(count));

  // R2
  idle_nowrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !wrap);

  // R3
  up_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && up && count < TOP) |=> (count == $past(count) + W'(1)));

  // R4
  down_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !up && count != '0 && count <= TOP) |=> (count == $past(count) - W'(1)));

  // R5
  up_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && up && count == TOP) |-> wrap ##1 (count == '0));

  // R6
  down_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !up && count == '0) |-> wrap ##1 (count == TOP));

  // R8
  recover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count > TOP) |-> !wrap ##1 (count == '0));
endmodule

bind mod5_updown_counter mod5_chk #(.MODULUS(MODULUS), .W(W)) u_chk (
  .clk   (clk),
  .rst_n (rst_q_n),
  .en    (en),
  .up    (up),
  .wrap  (wrap),
  .count (count)
);

// File: tb/mod5_updown_counter_tb.sv
module mod5_updown_counter_tb;
  import mod5_pkg::*;

  logic clk = 1'b0;
  logic rst_n, en, up, en2, up2;
  logic w_d, w_t, w_jk, w5, w6, w7;
  logic [2:0] c_d, c_t, c_jk, c5, c6, c7;
  int errors = 0;
  int checks = 0;
  int st = 0;

  always #4 clk = ~clk;

  mod5_updown_counter #(.EXCITE(EXC_D))  u_dut    (.clk(clk), .rst_n(rst_n), .en(en), .up(up), .wrap(w_d),  .count(c_d));
  mod5_updown_counter #(.EXCITE(EXC_T))  u_dut_t  (.clk(clk), .rst_n(rst_n), .en(en), .up(up), .wrap(w_t),  .count(c_t));
  mod5_updown_counter #(.EXCITE(EXC_JK)) u_dut_jk (.clk(clk), .rst_n(rst_n), .en(en), .up(up), .wrap(w_jk), .count(c_jk));
  mod5_updown_counter #(.EXCITE(EXC_D),  .SEED(5)) u_rec5 (.clk(clk), .rst_n(rst_n), .en(en2), .up(up2), .wrap(w5), .count(c5));
  mod5_updown_counter #(.EXCITE(EXC_T),  .SEED(6)) u_rec6 (.clk(clk), .rst_n(rst_n), .en(en2), .up(up2), .wrap(w6), .count(c6));
  mod5_updown_counter #(.EXCITE(EXC_JK), .SEED(7)) u_rec7 (.clk(clk), .rst_n(rst_n), .en(en2), .up(up2), .wrap(w7), .count(c7));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_all_counts(input string req, input int exp);
    chk(c_d  == exp, {req, " D"},  c_d,  exp);
    chk(c_t  == exp, {req, " T"},  c_t,  exp);
    chk(c_jk == exp, {req, " JK"}, c_jk, exp);
  endtask

  task automatic step(input logic e, input logic u, input string req);
    int exp_w;
    @(negedge clk);
    en = e;
    up = u;
    #1;
    exp_w = (e && ((u && st == 4) || (!u && st == 0))) ? 1 : 0;
    // R7 wrap must follow the inputs within the cycle
    chk(w_d  == exp_w, {req, " R7 wrap D"},  w_d,  exp_w);
    chk(w_t  == exp_w, {req, " R7 wrap T"},  w_t,  exp_w);
    chk(w_jk == exp_w, {req, " R7 wrap JK"}, w_jk, exp_w);
    @(posedge clk);
    if (e) st = u ? (st + 1) % 5 : (st + 4) % 5;
    #1;
    // R9 R10 all variants agree with the model after the edge
    chk_all_counts({req, " R9"}, st);
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; en = 1'b0; up = 1'b0; en2 = 1'b1; up2 = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk_all_counts("R1 reset", 0);
    // R8 unused codes present during reset give no wrap
    chk(c5 == 5 && w5 == 0, "R8 seed5", {c5, w5}, 10);
    chk(c6 == 6 && w6 == 0, "R8 seed6", {c6, w6}, 12);
    chk(c7 == 7 && w7 == 0, "R8 seed7", {c7, w7}, 14);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    @(posedge clk); #1;
    // R1 two edges after release the reset value still holds
    chk(c5 == 5, "R1 sync release", c5, 5);
    chk(c7 == 7, "R1 sync release", c7, 7);
    @(posedge clk); #1;
    // R8 recovery to 000 on the first active edge
    chk(c5 == 0, "R8 recover D", c5, 0);
    chk(c6 == 0, "R8 recover T", c6, 0);
    chk(c7 == 0, "R8 recover JK", c7, 0);
    @(posedge clk); #1;
    chk(c5 == 1 && c6 == 1 && c7 == 1, "R8 resume", c5, 1);
    en2 = 1'b0;

    for (int i = 0; i < 3; i++) step(1'b0, i[0], "R2 idle");
    for (int i = 0; i < 6; i++) step(1'b1, 1'b1, "R3 R5 up");
    for (int i = 0; i < 6; i++) step(1'b1, 1'b0, "R4 R6 down");
    for (int i = 0; i < 4; i++) step(1'b0, i[1], "R2 hold");
    // direction flips at the range ends
    step(1'b1, 1'b0, "R6 flip");
    step(1'b1, 1'b1, "R5 flip");
    step(1'b1, 1'b0, "R6 flip");
    for (int i = 0; i < 400; i++) step(1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 1)), "R9 random");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule